// File: doc/BRIEF.md
# Cross-User Detection-Stage LMS Filter

This block is the second filter of a two-stage linear multiuser receiver. The first stage gives one real soft value per user for each symbol. Those values arrive here as one K-wide vector per symbol. The block keeps the three most recent vectors in a circular window. From the vectors for symbols n−1, n and n+1 it forms a regressor of 3K entries. It then runs a real-valued LMS filter over that regressor for each user, one user after another. The result of each filter is a soft output and a hard decision taken from its sign.

Each vector carries a training flag and one known symbol per user. When a processed symbol is flagged as training, each user's coefficient vector is adapted after its output is formed. The adaptation uses the error between the known symbol and the output. The step size is a power of two, so the step is applied as a right shift. Without the flag, the coefficients are left untouched and only decisions are produced. Symbol n is processed only when the vector of symbol n+1 is accepted. While the block is processing, it refuses new vectors.

Top module: `mud_det_stage`

## Requirements
- R1: After reset, in_ready is 1, busy is 0 and dec_valid is 0. Every coefficient is zero and every window slot holds zeros, so the first processed symbol gives dec_soft = 0 for every user.
- R2: The regressor entry with index j = g*K + u (g in 0..2, u in 0..K−1) is user u's value for symbol n−1+g. A symbol before the first accepted vector counts as zero. Coefficient j of user k multiplies regressor entry j.
- R3: A vector is accepted on a rising edge where vec_valid and in_ready are both 1. Accepting the vector of symbol n+1 starts the processing of symbol n. The very first accepted vector starts no processing.
- R4: Inputs, coefficients and dec_soft are signed 16-bit values with 12 fraction bits. Each product is accumulated into a signed 32-bit sum that saturates after every addition. The output o is that sum shifted arithmetically right by 12 and saturated to 16 bits.
- R5: dec_bit is 0 when o ≥ 0 (a decided +1) and 1 when o < 0 (a decided −1). dec_soft carries o.
- R6: When the processed symbol's training flag is 1, each user's error is e = sat16(t − o), where t is +4096 for a training bit of 0 and −4096 for a bit of 1. Each coefficient j becomes sat16(c_j + ((x_j·e) >>> 14)). This applies a step of 2^−2.
- R7: When the processed symbol's training flag is 0, no coefficient changes.
- R8: Users are processed in order 0..K−1. Let D be 3K+1 cycles without training and 6K+1 cycles with training. The result of user u shows on dec_valid after the (u·D + 3K + 1)-th rising edge following the accept edge. busy falls after edge K·D.
- R9: A vector presented while busy is 1 has no effect on the window or on any later result.
- R10: dec_valid is a single-cycle pulse for each user result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_valid | input | 1 | A symbol vector is presented |
| vec_y | input | K*16 | First-stage outputs; user u in bits u*16 +: 16 |
| vec_train | input | 1 | The presented symbol is a training symbol |
| vec_bits | input | K | Known symbols of the presented symbol, bit u for user u (0 = +1, 1 = −1) |
| in_ready | output | 1 | A vector can be accepted |
| busy | output | 1 | A symbol is being processed |
| dec_valid | output | 1 | One user result is present |
| dec_user | output | clog2(K) | Index of the user whose result is present |
| dec_bit | output | 1 | Hard decision (0 = +1, 1 = −1) |
| dec_soft | output | 16 | Saturated filter output o |

## Verification
Every user result has a fixed due cycle, counted in rising edges after the accept edge. The count is 3K+1 for the first user, and each later user adds D, which depends on the training flag of the symbol being processed. The bench counts edges from the accept edge and samples dec_valid, busy and the result fields at every falling edge in between. At each sample it requires dec_valid to be high exactly at the computed edge and low elsewhere, and busy to fall exactly after K·D edges. The expected values come from a bench model that holds its own window history and coefficient arrays. That model applies the saturation, shift and order rules, so the effects of earlier training steps and of ignored vectors show up in later decisions.

// File: rtl/mud_det_pkg.sv
package mud_det_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MAC  = 2'd1,
        ST_DEC  = 2'd2,
        ST_UPD  = 2'd3
    } det_state_e;

    function automatic logic [1:0] slot_inc(input logic [1:0] s);
        return (s == 2'd2) ? 2'd0 : s + 2'd1;
    endfunction
endpackage

// File: rtl/mud_det_window.sv
module mud_det_window #(
    parameter int K  = 4,
    parameter int W  = 16,
    parameter int UW = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_slot,
    input  logic [K*W-1:0]      wr_y,
    input  logic                wr_train,
    input  logic [K-1:0]        wr_bits,
    input  logic [1:0]          rd_slot,
    input  logic [UW-1:0]       rd_col,
    output logic signed [W-1:0] rd_y,
    input  logic [1:0]          trn_slot,
    output logic                trn_flag,
    output logic [K-1:0]        trn_bits
);
    logic [K*W-1:0] y_q    [3];
    logic [K-1:0]   bits_q [3];
    logic [2:0]     flag_q;
    logic [K*W-1:0] row;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                y_q[i]    <= '0;
                bits_q[i] <= '0;
            end
            flag_q <= '0;
        end else begin
            for (int i = 0; i < 3; i++) begin
                if (wr_en && wr_slot == 2'(i)) begin
                    y_q[i]    <= wr_y;
                    bits_q[i] <= wr_bits;
                    flag_q[i] <= wr_train;
                end
            end
        end
    end

    always_comb begin
        row      = '0;
        trn_flag = 1'b0;
        trn_bits = '0;
        for (int i = 0; i < 3; i++) begin
            if (rd_slot == 2'(i)) row = y_q[i];
            if (trn_slot == 2'(i)) begin
                trn_flag = flag_q[i];
                trn_bits = bits_q[i];
            end
        end
        rd_y = row[int'(rd_col)*W +: W];
    end
endmodule

// File: rtl/mud_det_coef_mem.sv
module mud_det_coef_mem #(
    parameter int W   = 16,
    parameter int CAW = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CAW-1:0]      addr,
    output logic signed [W-1:0] rd_data,
    input  logic                wr_en,
    input  logic signed [W-1:0] wr_data
);
    localparam int DEPTH = 1 << CAW;

    logic signed [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[addr];
endmodule

// File: rtl/mud_det_stage.sv
module mud_det_stage
    import mud_det_pkg::*;
#(
    parameter int K        = 4,
    parameter int W        = 16,
    parameter int FRAC     = 12,
    parameter int NU_SHIFT = 2,
    localparam int UW      = (K > 1) ? $clog2(K) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vec_valid,
    input  logic [K*W-1:0]      vec_y,
    input  logic                vec_train,
    input  logic [K-1:0]        vec_bits,
    output logic                in_ready,
    output logic                busy,
    output logic                dec_valid,
    output logic [UW-1:0]       dec_user,
    output logic                dec_bit,
    output logic signed [W-1:0] dec_soft
);
    localparam int N   = 3 * K;
    localparam int CAW = $clog2(K * N);
    localparam int AW  = 2 * W;
    localparam logic signed [AW-1:0] WMAX = AW'(2 ** (W - 1) - 1);
    localparam logic signed [AW-1:0] WMIN = -WMAX - AW'(1);
    localparam logic signed [AW-1:0] ONE  = AW'(2 ** FRAC);
    localparam logic [UW-1:0]        LASTU = UW'(K - 1);

    typedef struct packed {
        det_state_e          st;
        logic [1:0]          wp;
        logic                seen;
        logic [1:0]          base;
        logic [UW-1:0]       user;
        logic [1:0]          grp;
        logic [UW-1:0]       col;
        logic signed [AW-1:0] acc;
        logic signed [W-1:0] err;
        logic                dv;
        logic                dbit;
        logic [UW-1:0]       duser;
        logic signed [W-1:0] dsoft;
    } ctl_t;

    ctl_t s_d, s_q;

    function automatic logic signed [W-1:0] sat_w(input logic signed [AW-1:0] v);
        if (v > WMAX) return WMAX[W-1:0];
        else if (v < WMIN) return WMIN[W-1:0];
        else return v[W-1:0];
    endfunction

    function automatic logic signed [AW-1:0] sat_acc(input logic signed [AW:0] s);
        if (s[AW] != s[AW-1]) return s[AW] ? {1'b1, {(AW-1){1'b0}}} : {1'b0, {(AW-1){1'b1}}};
        else return s[AW-1:0];
    endfunction

    logic                accept;
    logic [1:0]          rd_slot;
    logic signed [W-1:0] x_tap, c_tap, c_new, o_val;
    logic                trn_flag;
    logic [K-1:0]        trn_bits;
    logic [CAW-1:0]      caddr;
    logic signed [AW-1:0] xe, ce, prod_mac, prod_upd, delta, o_full, tgt;
    logic signed [AW:0]  mac_sum;
    logic                last_tap;

    assign accept = vec_valid && (s_q.st == ST_IDLE);

    always_comb begin
        case (s_q.grp)
            2'd0:    rd_slot = s_q.base;
            2'd1:    rd_slot = slot_inc(s_q.base);
            default: rd_slot = slot_inc(slot_inc(s_q.base));
        endcase
    end

    mud_det_window #(.K(K), .W(W), .UW(UW)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (accept),
        .wr_slot  (s_q.wp),
        .wr_y     (vec_y),
        .wr_train (vec_train),
        .wr_bits  (vec_bits),
        .rd_slot  (rd_slot),
        .rd_col   (s_q.col),
        .rd_y     (x_tap),
        .trn_slot (slot_inc(s_q.base)),
        .trn_flag (trn_flag),
        .trn_bits (trn_bits)
    );

    assign caddr = CAW'(int'(s_q.user) * N + int'(s_q.grp) * K + int'(s_q.col));

    mud_det_coef_mem #(.W(W), .CAW(CAW)) u_coef (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (caddr),
        .rd_data (c_tap),
        .wr_en   (s_q.st == ST_UPD),
        .wr_data (c_new)
    );

    always_comb begin
        xe       = AW'(x_tap);
        ce       = AW'(c_tap);
        prod_mac = xe * ce;
        mac_sum  = $signed({s_q.acc[AW-1], s_q.acc}) + $signed({prod_mac[AW-1], prod_mac});
        o_full   = s_q.acc >>> FRAC;
        o_val    = sat_w(o_full);
        tgt      = trn_bits[s_q.user] ? -ONE : ONE;
        prod_upd = xe * AW'(s_q.err);
        delta    = prod_upd >>> (FRAC + NU_SHIFT);
        c_new    = sat_w(ce + delta);
        last_tap = (s_q.grp == 2'd2) && (s_q.col == LASTU);
    end

    always_comb begin
        s_d    = s_q;
        s_d.dv = 1'b0;
        if (accept) begin
            s_d.wp   = slot_inc(s_q.wp);
            s_d.seen = 1'b1;
            if (s_q.seen) begin
                s_d.st   = ST_MAC;
                s_d.base = slot_inc(s_q.wp);
                s_d.user = '0;
                s_d.grp  = 2'd0;
                s_d.col  = '0;
                s_d.acc  = '0;
            end
        end
        case (s_q.st)
            ST_MAC: begin
                s_d.acc = sat_acc(mac_sum);
                if (last_tap) begin
                    s_d.st = ST_DEC;
                end else if (s_q.col == LASTU) begin
                    s_d.col = '0;
                    s_d.grp = s_q.grp + 2'd1;
                end else begin
                    s_d.col = s_q.col + UW'(1);
                end
            end
            ST_DEC: begin
                s_d.dv    = 1'b1;
                s_d.duser = s_q.user;
                s_d.dsoft = o_val;
                s_d.dbit  = o_val[W-1];
                s_d.err   = sat_w(tgt - AW'(o_val));
                s_d.grp   = 2'd0;
                s_d.col   = '0;
                s_d.acc   = '0;
                if (trn_flag) begin
                    s_d.st = ST_UPD;
                end else if (s_q.user == LASTU) begin
                    s_d.st = ST_IDLE;
                end else begin
                    s_d.st   = ST_MAC;
                    s_d.user = s_q.user + UW'(1);
                end
            end
            ST_UPD: begin
                if (last_tap) begin
                    s_d.grp = 2'd0;
                    s_d.col = '0;
                    if (s_q.user == LASTU) begin
                        s_d.st = ST_IDLE;
                    end else begin
                        s_d.st   = ST_MAC;
                        s_d.user = s_q.user + UW'(1);
                    end
                end else if (s_q.col == LASTU) begin
                    s_d.col = '0;
                    s_d.grp = s_q.grp + 2'd1;
                end else begin
                    s_d.col = s_q.col + UW'(1);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready  = (s_q.st == ST_IDLE);
    assign busy      = (s_q.st != ST_IDLE);
    assign dec_valid = s_q.dv;
    assign dec_user  = s_q.duser;
    assign dec_bit   = s_q.dbit;
    assign dec_soft  = s_q.dsoft;
endmodule

// File: rtl/mud_det_stage_chk.sv
module mud_det_stage_chk #(
    parameter int K  = 4,
    parameter int W  = 16,
    parameter int UW = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                vec_valid,
    input logic                in_ready,
    input logic                busy,
    input logic                dec_valid,
    input logic [UW-1:0]       dec_user,
    input logic                dec_bit,
    input logic signed [W-1:0] dec_soft
);
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    assert_user_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (int'(dec_user) <= K - 1));

    assert_result_in_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(busy));

    assert_sign_rule_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_bit == dec_soft[W-1]));

    assert_start_on_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(vec_valid && in_ready));
endmodule

bind mud_det_stage mud_det_stage_chk #(.K(K), .W(W), .UW(UW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vec_valid (vec_valid),
    .in_ready  (in_ready),
    .busy      (busy),
    .dec_valid (dec_valid),
    .dec_user  (dec_user),
    .dec_bit   (dec_bit),
    .dec_soft  (dec_soft)
);

// File: tb/mud_det_stage_tb.sv
`timescale 1ns/1ps
module mud_det_stage_tb;
    localparam int K  = 4;
    localparam int W  = 16;
    localparam int UW = 2;
    localparam int N  = 3 * K;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                vec_valid = 1'b0;
    logic [K*W-1:0]      vec_y = '0;
    logic                vec_train = 1'b0;
    logic [K-1:0]        vec_bits = '0;
    logic                in_ready, busy, dec_valid, dec_bit;
    logic [UW-1:0]       dec_user;
    logic signed [W-1:0] dec_soft;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    longint hist [0:63][0:K-1];
    bit     hist_tr [0:63];
    bit     hist_tb [0:63][0:K-1];
    longint cm [0:K-1][0:N-1];
    int     nsym = 0;

    always #4 clk = ~clk;

    mud_det_stage #(.K(K), .W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_y(vec_y),
        .vec_train(vec_train), .vec_bits(vec_bits), .in_ready(in_ready),
        .busy(busy), .dec_valid(dec_valid), .dec_user(dec_user),
        .dec_bit(dec_bit), .dec_soft(dec_soft)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint sat(input longint v, input int b);
        longint mx, mn;
        mx = (longint'(1) <<< (b - 1)) - 1;
        mn = -mx - 1;
        if (v > mx) return mx;
        if (v < mn) return mn;
        return v;
    endfunction

    function automatic int yval(input int sym, input int u, input int big);
        if (big != 0) return ((sym + u) % 2 == 0) ? 32767 : 30000;
        return (((sym * 37 + u * 53 + 11) % 97) - 48) * 80;
    endfunction

    // Presents one vector and checks all results it triggers, cycle by cycle.
    task automatic send(input int big, input bit train, input bit inject);
        int idx, m, dur, total, eu;
        longint acc, x, o, beta, tg;
        longint eo [0:K-1];
        while (!in_ready) @(negedge clk);
        idx = nsym;
        for (int u = 0; u < K; u++) begin
            hist[idx][u] = yval(idx, u, big);
            hist_tb[idx][u] = ((idx + u) % 3 == 0);
            vec_y[u*W +: W] = W'(yval(idx, u, big));
            vec_bits[u] = ((idx + u) % 3 == 0);
        end
        hist_tr[idx] = train;
        vec_train = train;
        vec_valid = 1'b1;
        @(negedge clk);
        vec_valid = 1'b0;
        nsym++;
        if (idx == 0) begin
            for (int c = 1; c <= 6; c++) begin
                chk(!dec_valid && !busy, "R3 first vector starts nothing", dec_valid, 0);
                @(negedge clk);
            end
            return;
        end
        m = idx - 1;
        for (int k = 0; k < K; k++) begin
            acc = 0;
            for (int j = 0; j < N; j++) begin
                int s;
                s = m - 1 + j / K;
                x = (s < 0) ? 0 : hist[s][j % K];
                acc = sat(acc + x * cm[k][j], 32);
            end
            o = sat(acc >>> 12, 16);
            eo[k] = o;
            if (hist_tr[m]) begin
                tg = hist_tb[m][k] ? -4096 : 4096;
                beta = sat(tg - o, 16);
                for (int j = 0; j < N; j++) begin
                    int s;
                    s = m - 1 + j / K;
                    x = (s < 0) ? 0 : hist[s][j % K];
                    cm[k][j] = sat(cm[k][j] + ((x * beta) >>> 14), 16);
                end
            end
        end
        dur = hist_tr[m] ? 6 * K + 1 : 3 * K + 1;
        total = K * dur;
        for (int c = 1; c <= total + 1; c++) begin
            @(negedge clk);
            eu = -1;
            for (int u = 0; u < K; u++) if (c == u * dur + 3 * K + 1) eu = u;
            chk(dec_valid == (eu >= 0), "R8/R10 dec_valid timing", dec_valid, (eu >= 0));
            chk(busy == (c < total), "R8 busy span", busy, (c < total));
            if (eu >= 0) begin
                chk(dec_user == UW'(eu), "R8 user order", dec_user, eu);
                chk(dec_soft == eo[eu], "R2/R4/R6 soft output", dec_soft, eo[eu]);
                chk(dec_bit == (eo[eu] < 0), "R5 decision bit", dec_bit, (eo[eu] < 0));
            end
            if (inject && c == 2) begin
                vec_valid = 1'b1;
                vec_y = {K{16'h7abc}};
                vec_train = 1'b1;
            end
            if (inject && c == 5) vec_valid = 1'b0;
        end
        vec_valid = 1'b0;
    endtask

    task automatic test_reset;
        chk(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
        chk(busy == 1'b0, "R1 idle after reset", busy, 0);
        chk(dec_valid == 1'b0, "R1 no result after reset", dec_valid, 0);
    endtask

    task automatic test_first_vector;   // R3
        send(0, 1'b1, 1'b0);
    endtask

    task automatic test_zero_start;     // R1: zero coefficients give o = 0
        send(0, 1'b1, 1'b0);
    endtask

    task automatic test_training;       // R2, R4, R6
        for (int i = 0; i < 5; i++) send(0, 1'b1, 1'b0);
    endtask

    task automatic test_detect_only;    // R7: repeated results follow unchanged coefficients
        for (int i = 0; i < 3; i++) send(0, 1'b0, 1'b0);
    endtask

    task automatic test_ignore_busy;    // R9
        send(0, 1'b0, 1'b1);
        send(0, 1'b1, 1'b1);
        send(0, 1'b0, 1'b0);
    endtask

    task automatic test_saturation;     // R4, R6 saturation paths
        for (int i = 0; i < 4; i++) send(1, 1'b1, 1'b0);
        send(1, 1'b0, 1'b0);
        send(0, 1'b0, 1'b0);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        for (int k = 0; k < K; k++)
            for (int j = 0; j < N; j++) cm[k][j] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_first_vector();
        test_zero_start();
        test_training();
        test_detect_only();
        test_ignore_busy();
        test_saturation();
        repeat (4) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end
endmodule